// File: doc/BRIEF.md
# Colour Lookup Table with Reduced Mode

This block sits in a display pipe and remaps every colour component of a pixel through a per-channel table of 256 entries, 10 bits each. Software or a loader fills the tables through a plain address/data write port. Pixels arrive on a valid/ready stream and leave on a second valid/ready stream. The horizontal sync, vertical sync and data-enable flags travel alongside each pixel, so they stay aligned with it.

Two control pins set how the lookup works. `lut_on` low sends components straight through. `lut_full` high picks direct indexing. `lut_full` low picks reduced indexing: only the middle half of each table is consulted, and odd input codes are filled in by averaging neighbouring entries. This lets a coarse 128-step curve serve all 256 input codes.

Back-pressure rules:
- A pixel is accepted on any clock edge where both `s_valid` and `s_ready` are high.
- A result is taken on any edge where both `m_valid` and `m_ready` are high.
- While `m_valid` is high and `m_ready` is low, the output word and its flags hold still.
- `s_ready` drops only when both internal stages are occupied and the output is stalled.

Top module: `clut_pipe`

## Requirements
- R1: After a clock edge with `rst_n` low, `m_valid` is low and `s_ready` is high.
- R2: A pixel accepted with `lut_on` low leaves with each 10-bit output component equal to its 8-bit input code shifted left by two (the two low bits are zero).
- R3: A pixel accepted with `lut_on` high and `lut_full` high leaves with component c equal to entry [code] of table c.
- R4: In reduced mode (`lut_on` high, `lut_full` low), an even code n yields entry 64 + n/2.
- R5: In reduced mode, an odd code n below 255 yields floor((entry 64+(n-1)/2 + entry 64+(n+1)/2) / 2).
- R6: In reduced mode, code 255 yields entry 191, with no blending beyond it.
- R7: In reduced mode, the contents of entries 0 to 63 and 192 to 255 have no effect on the output.
- R8: The input component c occupies `s_pix` bits [8c+7:8c], and the output component c occupies `m_pix` bits [10c+9:10c]. Table c is written when `wr_en` is high and `wr_ch` equals c. A `wr_ch` value of 3 or more writes nothing. A write on cycle t is seen by pixels accepted after t and not by a pixel accepted on cycle t.
- R9: Without stalls, a pixel accepted at edge t is presented on `m_pix` after edge t+1, together with the `s_hs`, `s_vs` and `s_de` values captured with it.
- R10: While `m_valid` is high and `m_ready` is low, `m_pix`, `m_hs`, `m_vs` and `m_de` hold. `s_ready` is high whenever `m_valid` is low. Pixels leave in order with none lost or repeated.
- R11: `lut_on` and `lut_full` are sampled per pixel at acceptance. Changing them afterwards does not alter a pixel already inside the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lut_on | input | 1 | 1 applies the tables, 0 passes codes through |
| lut_full | input | 1 | 1 direct indexing, 0 reduced indexing |
| wr_en | input | 1 | Table write strobe |
| wr_ch | input | 2 | Table (channel) selected for the write |
| wr_addr | input | 8 | Entry index for the write |
| wr_data | input | 10 | Entry value for the write |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can accept an input pixel |
| s_pix | input | 24 | Three 8-bit input components |
| s_hs | input | 1 | Horizontal sync flag of the input pixel |
| s_vs | input | 1 | Vertical sync flag of the input pixel |
| s_de | input | 1 | Data-enable flag of the input pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_pix | output | 30 | Three 10-bit output components |
| m_hs | output | 1 | Horizontal sync flag of the output pixel |
| m_vs | output | 1 | Vertical sync flag of the output pixel |
| m_de | output | 1 | Data-enable flag of the output pixel |

## Verification
A corrupted table entry, or a wrong index from the address stage, appears on `m_pix` two edges after the first pixel whose code selects that entry. Such a code can be in reduced mode, where the even and odd neighbours of an entry both depend on it. A stage valid flag that is stuck or lost shows up as a missing, repeated or reordered result, or as `s_ready` staying low while the output is empty, on the very next stalled or unstalled cycle. Flags that drift out of step with their pixel show as wrong sync or data-enable values on the same cycle the pixel appears.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // How a captured component is turned into an output value.
  typedef enum logic [1:0] {
    LK_PASS   = 2'd0,  // table off: widen the input code
    LK_DIRECT = 2'd1,  // single entry used as is
    LK_BLEND  = 2'd2   // mean of two adjacent entries
  } lk_kind_t;

  // Timing flags that ride along with each pixel.
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } side_t;

endpackage

// File: rtl/clut_addr_gen.sv
module clut_addr_gen
  import clut_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [IN_W-1:0] code,
  input  logic            on,
  input  logic            full,
  output logic [IN_W-1:0] idx_a,
  output logic [IN_W-1:0] idx_b,
  output lk_kind_t        kind
);

  localparam logic [IN_W-1:0] MID_BASE = IN_W'(1) << (IN_W - 2);
  localparam logic [IN_W-1:0] TOP_CODE = '1;

  logic [IN_W-1:0] half_idx;
  logic            odd_inner;

  // Reduced mode steps through the middle half at half speed.
  assign half_idx  = MID_BASE + (code >> 1);
  assign odd_inner = code[0] && (code != TOP_CODE);

  always_comb begin
    idx_a = code;
    idx_b = code;
    kind  = LK_PASS;
    if (on) begin
      if (full) begin
        kind = LK_DIRECT;
      end else begin
        idx_a = half_idx;
        idx_b = half_idx;
        kind  = LK_DIRECT;
        if (odd_inner) begin
          idx_b = half_idx + IN_W'(1);
          kind  = LK_BLEND;
        end
      end
    end
  end

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10,
  localparam int DEPTH = 1 << IN_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IN_W-1:0]  waddr,
  input  logic [OUT_W-1:0] wdata,
  input  logic [IN_W-1:0]  ra,
  input  logic [IN_W-1:0]  rb,
  output logic [OUT_W-1:0] qa,
  output logic [OUT_W-1:0] qb
);

  logic [OUT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Two asynchronous read ports: a write lands at the edge, so a read in
  // the same cycle still returns the previous contents.
  assign qa = mem[ra];
  assign qb = mem[rb];

endmodule

// File: rtl/clut_blend.sv
module clut_blend
  import clut_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10
) (
  input  lk_kind_t         kind,
  input  logic [IN_W-1:0]  code,
  input  logic [OUT_W-1:0] ent_a,
  input  logic [OUT_W-1:0] ent_b,
  output logic [OUT_W-1:0] y
);

  localparam int PAD = OUT_W - IN_W;

  logic [OUT_W-1:0] widened;
  logic [OUT_W-1:0] mean_ab;

  assign widened = OUT_W'(code) << PAD;
  assign mean_ab = OUT_W'(({1'b0, ent_a} + {1'b0, ent_b}) >> 1);

  always_comb begin
    unique case (kind)
      LK_DIRECT: y = ent_a;
      LK_BLEND:  y = mean_ab;
      default:   y = widened;
    endcase
  end

endmodule

// File: rtl/clut_pipe.sv
module clut_pipe
  import clut_pkg::*;
#(
  parameter int CH_N  = 3,
  parameter int IN_W  = 8,
  parameter int OUT_W = 10,
  localparam int SEL_W = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int PI_W  = CH_N * IN_W,
  localparam int PO_W  = CH_N * OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lut_on,
  input  logic             lut_full,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_ch,
  input  logic [IN_W-1:0]  wr_addr,
  input  logic [OUT_W-1:0] wr_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PI_W-1:0]  s_pix,
  input  logic             s_hs,
  input  logic             s_vs,
  input  logic             s_de,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PO_W-1:0]  m_pix,
  output logic             m_hs,
  output logic             m_vs,
  output logic             m_de
);

  // Stage handshakes: a stage may load when it is empty or draining.
  logic  s1_valid, m_valid_q;
  logic  s2_en, s1_en, take;
  side_t s1_side, m_side;

  assign s2_en   = !m_valid_q || m_ready;
  assign s1_en   = !s1_valid || s2_en;
  assign s_ready = s1_en;
  assign take    = s_valid && s1_en;
  assign m_valid = m_valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      m_valid_q <= 1'b0;
    end else begin
      if (s1_en) s1_valid  <= s_valid;
      if (s2_en) m_valid_q <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_side <= '0;
      m_side  <= '0;
    end else begin
      if (take)              s1_side <= '{hs: s_hs, vs: s_vs, de: s_de};
      if (s2_en && s1_valid) m_side  <= s1_side;
    end
  end

  assign m_hs = m_side.hs;
  assign m_vs = m_side.vs;
  assign m_de = m_side.de;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [IN_W-1:0]  code;
    logic [IN_W-1:0]  ia, ib;
    lk_kind_t         kind;
    logic [OUT_W-1:0] qa, qb;
    logic             bank_we;

    lk_kind_t         s1_kind;
    logic [IN_W-1:0]  s1_code;
    logic [OUT_W-1:0] s1_a, s1_b;
    logic [OUT_W-1:0] y, y_q;

    assign code    = s_pix[c*IN_W +: IN_W];
    assign bank_we = wr_en && (wr_ch == SEL_W'(c));

    clut_addr_gen #(.IN_W(IN_W)) u_addr (
      .code  (code),
      .on    (lut_on),
      .full  (lut_full),
      .idx_a (ia),
      .idx_b (ib),
      .kind  (kind)
    );

    clut_bank #(.IN_W(IN_W), .OUT_W(OUT_W)) u_bank (
      .clk   (clk),
      .we    (bank_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .ra    (ia),
      .rb    (ib),
      .qa    (qa),
      .qb    (qb)
    );

    // Stage 1 holds the fetched entries, so control and table contents
    // are frozen at the moment of acceptance.
    always_ff @(posedge clk) begin
      if (take) begin
        s1_kind <= kind;
        s1_code <= code;
        s1_a    <= qa;
        s1_b    <= qb;
      end
    end

    clut_blend #(.IN_W(IN_W), .OUT_W(OUT_W)) u_blend (
      .kind  (s1_kind),
      .code  (s1_code),
      .ent_a (s1_a),
      .ent_b (s1_b),
      .y     (y)
    );

    always_ff @(posedge clk) begin
      if (s2_en && s1_valid) y_q <= y;
    end

    assign m_pix[c*OUT_W +: OUT_W] = y_q;
  end

endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
  parameter int CH_N  = 3,
  parameter int IN_W  = 8,
  parameter int OUT_W = 10,
  localparam int PI_W = CH_N * IN_W,
  localparam int PO_W = CH_N * OUT_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lut_on,
  input logic            s_valid,
  input logic            s_ready,
  input logic [PI_W-1:0] s_pix,
  input logic            s_hs,
  input logic            s_vs,
  input logic            s_de,
  input logic            m_valid,
  input logic            m_ready,
  input logic [PO_W-1:0] m_pix,
  input logic            m_hs,
  input logic            m_vs,
  input logic            m_de
);

  function automatic logic [PO_W-1:0] widen_all(input logic [PI_W-1:0] p);
    logic [PO_W-1:0] r;
    for (int c = 0; c < CH_N; c++) begin
      r[c*OUT_W +: OUT_W] = OUT_W'(p[c*IN_W +: IN_W]) << (OUT_W - IN_W);
    end
    return r;
  endfunction

  logic acc;
  assign acc = s_valid && s_ready;

  // R1: reset empties the output stage and opens the input.
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!m_valid && s_ready));

  // R10: stalled output holds data and flags.
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix) && $stable({m_hs, m_vs, m_de})));

  // R10: an empty output never blocks the input.
  p_open_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  // R2: pass-through pixel arrives two edges later, widened.
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !lut_on) ##1 (m_ready || !m_valid) |=> (m_valid && m_pix == widen_all($past(s_pix, 2))));

  // R9: flags arrive with their pixel.
  p_flags_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc ##1 (m_ready || !m_valid) |=> (m_valid && {m_hs, m_vs, m_de} == $past({s_hs, s_vs, s_de}, 2)));

endmodule

bind clut_pipe clut_chk #(.CH_N(CH_N), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lut_on  (lut_on),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_pix   (s_pix),
  .s_hs    (s_hs),
  .s_vs    (s_vs),
  .s_de    (s_de),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_pix   (m_pix),
  .m_hs    (m_hs),
  .m_vs    (m_vs),
  .m_de    (m_de)
);

// File: tb/sim_clut_pipe.sv
module sim_clut_pipe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lut_on = 1'b0, lut_full = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [7:0]  wr_addr = '0;
  logic [9:0]  wr_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_pix = '0;
  logic        s_hs = 1'b0, s_vs = 1'b0, s_de = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [29:0] m_pix;
  logic        m_hs, m_vs, m_de;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  clut_pipe u0 (
    .clk(clk), .rst_n(rst_n), .lut_on(lut_on), .lut_full(lut_full),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr), .wr_data(wr_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_pix(s_pix),
    .s_hs(s_hs), .s_vs(s_vs), .s_de(s_de),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix),
    .m_hs(m_hs), .m_vs(m_vs), .m_de(m_de)
  );

  // Bench copy of the table contents, maintained from the writes it issues.
  logic [9:0] tbl [3][256];

  // Stimulus vectors: {on, full, code}.
  localparam int NV = 18;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd0},   {1'b0, 1'b1, 8'd171}, {1'b0, 1'b0, 8'd255},
    {1'b1, 1'b1, 8'd0},   {1'b1, 1'b1, 8'd77},  {1'b1, 1'b1, 8'd255},
    {1'b1, 1'b0, 8'd0},   {1'b1, 1'b0, 8'd2},   {1'b1, 1'b0, 8'd128},
    {1'b1, 1'b0, 8'd254}, {1'b1, 1'b0, 8'd1},   {1'b1, 1'b0, 8'd3},
    {1'b1, 1'b0, 8'd127}, {1'b1, 1'b0, 8'd129}, {1'b1, 1'b0, 8'd253},
    {1'b1, 1'b0, 8'd255}, {1'b1, 1'b0, 8'd200}, {1'b1, 1'b0, 8'd64}
  };

  function automatic logic [9:0] seed(input int c, input int i);
    return 10'((i * 37 + c * 211) ^ (i >> 3));
  endfunction

  function automatic logic [9:0] exp_one(input int c, input logic [7:0] n,
                                         input logic on, input logic full);
    int k;
    if (!on) return {n, 2'b00};
    if (full) return tbl[c][n];
    k = 64 + (int'(n) >> 1);
    if (n[0] && n != 8'hff) return 10'((int'(tbl[c][k]) + int'(tbl[c][k+1])) >> 1);
    return tbl[c][k];
  endfunction

  function automatic logic [29:0] exp_pix(input logic [23:0] p, input logic on,
                                          input logic full);
    logic [29:0] r;
    for (int c = 0; c < 3; c++) r[c*10 +: 10] = exp_one(c, p[c*8 +: 8], on, full);
    return r;
  endfunction

  function automatic logic [23:0] mk_pix(input logic [7:0] code);
    return {code + 8'd1, ~code, code};
  endfunction

  function automatic string tag_of(input logic on, input logic full, input logic [7:0] n);
    if (!on) return "R2";
    if (full) return "R3";
    if (n == 8'hff) return "R6";
    if (n[0]) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [29:0] got, input logic [29:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_ent(input logic [1:0] c, input logic [7:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = c; wr_addr = a; wr_data = d;
    if (c < 2'd3) tbl[c][a] = d;
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One pixel through an otherwise idle pipe; flip toggles controls after acceptance.
  task automatic send_pix(input string tag, input logic [23:0] p, input logic on,
                          input logic full, input logic [2:0] side, input bit flip);
    logic [29:0] e;
    e = exp_pix(p, on, full);
    @(negedge clk);
    s_pix = p; lut_on = on; lut_full = full; {s_hs, s_vs, s_de} = side; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    if (flip) begin lut_on = !on; lut_full = !full; end
    chk("R9 latency", 30'(m_valid), 30'd0);
    @(negedge clk);
    chk("R9 valid", 30'(m_valid), 30'd1);
    chk(tag, m_pix, e);
    chk("R9 flags", 30'({m_hs, m_vs, m_de}), 30'(side));
  endtask

  initial begin : main
    logic [29:0] e0, e1, e2;
    logic [29:0] held;
    repeat (3) @(negedge clk);
    chk("R1 m_valid", 30'(m_valid), 30'd0);
    chk("R1 s_ready", 30'(s_ready), 30'd1);
    rst_n = 1'b1;

    // Load all three tables.
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 256; i++) write_ent(2'(c), 8'(i), seed(c, i));
    wr_idle();

    // Vector walk.
    for (int v = 0; v < NV; v++)
      send_pix(tag_of(VEC[v][9], VEC[v][8], VEC[v][7:0]), mk_pix(VEC[v][7:0]),
               VEC[v][9], VEC[v][8], 3'(v), 1'b0);

    // R7: flood outer entries; reduced results must not move.
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 64; i++) begin
        write_ent(2'(c), 8'(i), 10'h3ff);
        write_ent(2'(c), 8'(i + 192), 10'h3ff);
      end
    wr_idle();
    send_pix("R7 low", mk_pix(8'd0), 1'b1, 1'b0, 3'b001, 1'b0);
    send_pix("R7 high", mk_pix(8'd255), 1'b1, 1'b0, 3'b010, 1'b0);
    send_pix("R7 odd", mk_pix(8'd253), 1'b1, 1'b0, 3'b100, 1'b0);
    send_pix("R7 outer in full", mk_pix(8'd0), 1'b1, 1'b1, 3'b111, 1'b0);

    // R8: channel select 3 writes nothing.
    write_ent(2'd3, 8'd100, 10'h000);
    wr_idle();
    send_pix("R8 ignored select", {8'd100, 8'd100, 8'd100}, 1'b1, 1'b1, 3'b000, 1'b0);

    // R8: write and pixel on the same cycle; pixel sees old value.
    e0 = exp_pix(mk_pix(8'd50), 1'b1, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'd0; wr_addr = 8'd50; wr_data = 10'h2a5;
    s_pix = mk_pix(8'd50); lut_on = 1'b1; lut_full = 1'b1; s_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; s_valid = 1'b0;
    tbl[0][50] = 10'h2a5;
    @(negedge clk);
    chk("R8 same-cycle write", m_pix, e0);
    send_pix("R8 next pixel", mk_pix(8'd50), 1'b1, 1'b1, 3'b000, 1'b0);

    // R11: controls flipped after acceptance.
    send_pix("R11 flip on", mk_pix(8'd129), 1'b1, 1'b0, 3'b011, 1'b1);
    send_pix("R11 flip off", mk_pix(8'd129), 1'b0, 1'b1, 3'b110, 1'b1);

    // R10: back-pressure with three pixels.
    e0 = exp_pix(mk_pix(8'd10), 1'b1, 1'b1);
    e1 = exp_pix(mk_pix(8'd11), 1'b1, 1'b0);
    e2 = exp_pix(mk_pix(8'd12), 1'b0, 1'b0);
    @(negedge clk);
    m_ready = 1'b0;
    s_pix = mk_pix(8'd10); lut_on = 1'b1; lut_full = 1'b1; s_valid = 1'b1;
    @(negedge clk);
    s_pix = mk_pix(8'd11); lut_on = 1'b1; lut_full = 1'b0;
    @(negedge clk);
    s_pix = mk_pix(8'd12); lut_on = 1'b0; lut_full = 1'b0;
    chk("R10 s_ready low when full", 30'(s_ready), 30'd0);
    chk("R10 first out", m_pix, e0);
    held = m_pix;
    repeat (3) @(negedge clk);
    chk("R10 hold", m_pix, held);
    chk("R10 still stalled", 30'({m_valid, s_ready}), 30'b10);
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R10 second out", m_pix, e1);
    @(negedge clk);
    chk("R10 third out", m_pix, e2);
    chk("R10 third valid", 30'(m_valid), 30'd1);
    @(negedge clk);
    chk("R10 drained", 30'(m_valid), 30'd0);

    // R1: reset in mid-stream.
    @(negedge clk);
    s_pix = mk_pix(8'd5); s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", 30'({m_valid, s_ready}), 30'b01);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 nothing emerges", 30'(m_valid), 30'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule